// File: doc/BRIEF.md
# Conventional Page Table Walker

This block fills a translation-table miss for a conventional, single-level paging scheme. The translation table hands it a virtual address, an executive or user selection, and flags for a write, a map query and a console request. The block finds the memory word that holds the page's entry. It reads that word through a physical memory request/acknowledge port and picks the 18-bit half that belongs to the page. It then decides whether the access is allowed.

On success it returns an expanded entry to install: the physical page number plus a modified flag. On failure it returns a page-fail word for the trap logic. The process table bases are inputs, and the in-table offsets of the four map regions are module parameters. One memory read is in flight at most. A new request is accepted only when the walker is idle.

Executive pages are not held in one table. Low executive pages map from one region of the executive process table. A middle band maps from the user process table. The top half maps from a second region of the executive process table. All user pages map from one contiguous region of the user process table.

Top module: `pt_walker`

## Requirements
- R1: For a user request, the entry word address is userBase + USER_MAP_OFS + (page >> 1), where page is vaddr[17:9] and the sum is taken modulo 2^20.
- R2: For an executive request with page below octal 340, the entry word address is execBase + EXEC_LOW_OFS + (page >> 1).
- R3: For an executive request with page from octal 340 to octal 377, the entry word address is userBase + EXEC_MID_OFS + ((page - octal 340) >> 1).
- R4: For an executive request with page at octal 400 or above, the entry word address is execBase + EXEC_HIGH_OFS + ((page - octal 400) >> 1).
- R5: An odd page takes its entry from memRdata[17:0] and an even page takes it from memRdata[35:18]. Within the entry, bit 17 is accessible, bit 16 is writeable, bit 15 is software, bit 14 is cacheable and bits 10:0 are the physical page number.
- R6: `granted` is 1 exactly when the accessible bit is set and either the request is a read or the writeable bit is set.
- R7: On a grant, fillPpn equals the entry's bits 10:0 and fillMod equals its writeable bit.
- R8: failWord has bit 35 = 1 (virtual reference), bit 34 = user, bit 33 = write, bit 32 = accessible, bit 31 = software AND accessible, bits 17:0 = vaddr, and every other bit 0 when isMap is 0.
- R9: When isMap is 1, failWord bit 31 is the software bit alone, bit 30 is the writeable bit and bit 29 is the cacheable bit. All other fields are as in R8.
- R10: `install` pulses with `done` only for a granted request whose isConsole was 0. A console request still reports `granted` and the fill fields.
- R11: Each request issues exactly one memory read. memReq stays high and memAddr stays stable until memAck. memReq is low in the cycle after the acknowledge. `done` is a one-cycle pulse. A `start` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk; sampled only when idle |
| vaddr | input | 18 | Faulting virtual address |
| isUser | input | 1 | 1 selects the user address space |
| isWrite | input | 1 | Reference is a write |
| isMap | input | 1 | Request is a map query |
| isConsole | input | 1 | Request comes from the console; suppresses install |
| execBase | input | 20 | Physical base of the executive process table |
| userBase | input | 20 | Physical base of the user process table |
| memReq | output | 1 | Memory read request |
| memAddr | output | 20 | Physical word address of the read |
| memAck | input | 1 | Memory read data valid |
| memRdata | input | 36 | Memory read data |
| done | output | 1 | One-cycle completion pulse |
| granted | output | 1 | Access allowed; valid with done |
| install | output | 1 | Write the expanded entry into the translation table |
| fillPpn | output | 11 | Physical page number of the expanded entry |
| fillMod | output | 1 | Modified (writeable) flag of the expanded entry |
| failWord | output | 36 | Page-fail word; valid with done |

## Verification
A wrong region decision or a wrong base shows up as a bad memAddr. It is visible two cycles after start, before any data returns. A wrong half selection or a stale latched request flag shows up in fillPpn, granted or failWord on the done pulse. That pulse comes two cycles after the acknowledge. A sequencer stuck in a state leaves memReq or done high for too long, or never raises them. Every transaction waits on these with bounded polling, so the failure appears within a few cycles.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CALC,
    S_READ,
    S_CHECK,
    S_DONE
  } walkState_t;

  typedef struct packed {
    logic takeReq;
    logic takeAddr;
    logic takeEntry;
    logic takeResult;
  } walkStrobe_t;

  // bit positions inside an 18-bit table entry
  localparam int ENT_ACC   = 17;
  localparam int ENT_WR    = 16;
  localparam int ENT_SOFT  = 15;
  localparam int ENT_CACHE = 14;

  // bit positions inside the 36-bit page-fail word
  localparam int FW_VIRT  = 35;
  localparam int FW_USER  = 34;
  localparam int FW_WRITE = 33;
  localparam int FW_ACC   = 32;
  localparam int FW_SOFT  = 31;
  localparam int FW_WR    = 30;
  localparam int FW_CACHE = 29;

endpackage

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
  import pt_walk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        memAck,
  output walkStrobe_t strobe,
  output logic        memReq,
  output logic        done
);

  walkState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    memReq    = 1'b0;
    done      = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          strobe.takeReq = 1'b1;
          stateNext      = S_CALC;
        end
      end
      S_CALC: begin
        strobe.takeAddr = 1'b1;
        stateNext       = S_READ;
      end
      S_READ: begin
        memReq = 1'b1;
        if (memAck) begin
          strobe.takeEntry = 1'b1;
          stateNext        = S_CHECK;
        end
      end
      S_CHECK: begin
        strobe.takeResult = 1'b1;
        stateNext         = S_DONE;
      end
      S_DONE: begin
        done      = 1'b1;
        stateNext = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

endmodule

// File: rtl/pt_walk_dp.sv
module pt_walk_dp
  import pt_walk_pkg::*;
#(
  parameter int VA_W            = 18,
  parameter int OFS_W           = 9,
  parameter int PA_W            = 20,
  parameter int WORD_W          = 36,
  parameter int USER_MAP_OFS    = 'o0,
  parameter int EXEC_LOW_OFS    = 'o600,
  parameter int EXEC_MID_OFS    = 'o400,
  parameter int EXEC_HIGH_OFS   = 'o200,
  parameter int EXEC_MID_START  = 'o340,
  parameter int EXEC_HIGH_START = 'o400
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobe_t       strobe,
  input  logic              done,
  input  logic [VA_W-1:0]   vaddr,
  input  logic              isUser,
  input  logic              isWrite,
  input  logic              isMap,
  input  logic              isConsole,
  input  logic [PA_W-1:0]   execBase,
  input  logic [PA_W-1:0]   userBase,
  input  logic [WORD_W-1:0] memRdata,
  output logic [PA_W-1:0]   memAddr,
  output logic              granted,
  output logic              install,
  output logic [PA_W-OFS_W-1:0] fillPpn,
  output logic              fillMod,
  output logic [WORD_W-1:0] failWord
);

  localparam int PAGE_W = VA_W - OFS_W;
  localparam int HALF_W = WORD_W / 2;
  localparam int PPN_W  = PA_W - OFS_W;
  localparam logic [PAGE_W-1:0] MID_PG  = EXEC_MID_START[PAGE_W-1:0];
  localparam logic [PAGE_W-1:0] HIGH_PG = EXEC_HIGH_START[PAGE_W-1:0];
  localparam logic [PA_W-1:0] U_OFS  = USER_MAP_OFS[PA_W-1:0];
  localparam logic [PA_W-1:0] EL_OFS = EXEC_LOW_OFS[PA_W-1:0];
  localparam logic [PA_W-1:0] EM_OFS = EXEC_MID_OFS[PA_W-1:0];
  localparam logic [PA_W-1:0] EH_OFS = EXEC_HIGH_OFS[PA_W-1:0];

  logic [VA_W-1:0]   vaddrQ;
  logic              userQ, writeQ, mapQ, conQ;
  logic [PA_W-1:0]   execBaseQ, userBaseQ;
  logic [HALF_W-1:0] entryQ;
  logic              grantedQ, modQ;
  logic [PPN_W-1:0]  ppnQ;
  logic [WORD_W-1:0] failQ;

  logic [PAGE_W-1:0] page;
  assign page = vaddrQ[VA_W-1:OFS_W];

  // request capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaddrQ    <= '0;
      userQ     <= 1'b0;
      writeQ    <= 1'b0;
      mapQ      <= 1'b0;
      conQ      <= 1'b0;
      execBaseQ <= '0;
      userBaseQ <= '0;
    end else if (strobe.takeReq) begin
      vaddrQ    <= vaddr;
      userQ     <= isUser;
      writeQ    <= isWrite;
      mapQ      <= isMap;
      conQ      <= isConsole;
      execBaseQ <= execBase;
      userBaseQ <= userBase;
    end
  end

  // region decode and entry-pair address
  logic [PAGE_W-1:0] relPage;
  logic [PA_W-1:0]   regionBase, regionOfs, addrNext;

  always_comb begin
    if (userQ) begin
      regionBase = userBaseQ;
      regionOfs  = U_OFS;
      relPage    = page;
    end else if (page < MID_PG) begin
      regionBase = execBaseQ;
      regionOfs  = EL_OFS;
      relPage    = page;
    end else if (page < HIGH_PG) begin
      regionBase = userBaseQ;
      regionOfs  = EM_OFS;
      relPage    = page - MID_PG;
    end else begin
      regionBase = execBaseQ;
      regionOfs  = EH_OFS;
      relPage    = page - HIGH_PG;
    end
    addrNext = regionBase + regionOfs + {{(PA_W-PAGE_W){1'b0}}, (relPage >> 1)};
  end

  always_ff @(posedge clk) begin
    if (!rstN)               memAddr <= '0;
    else if (strobe.takeAddr) memAddr <= addrNext;
  end

  // half-word select: odd page right half, even page left half
  always_ff @(posedge clk) begin
    if (!rstN) entryQ <= '0;
    else if (strobe.takeEntry)
      entryQ <= page[0] ? memRdata[HALF_W-1:0] : memRdata[WORD_W-1:HALF_W];
  end

  // access check and fail word
  logic entAcc, entWr, entSoft, entCache, grantNow;
  logic [WORD_W-1:0] failNext;

  always_comb begin
    entAcc   = entryQ[ENT_ACC];
    entWr    = entryQ[ENT_WR];
    entSoft  = entryQ[ENT_SOFT];
    entCache = entryQ[ENT_CACHE];
    grantNow = entAcc & (~writeQ | entWr);
    failNext = '0;
    failNext[FW_VIRT]   = 1'b1;
    failNext[FW_USER]   = userQ;
    failNext[FW_WRITE]  = writeQ;
    failNext[FW_ACC]    = entAcc;
    failNext[FW_SOFT]   = entSoft & (entAcc | mapQ);
    failNext[FW_WR]     = entWr & mapQ;
    failNext[FW_CACHE]  = entCache & mapQ;
    failNext[VA_W-1:0]  = vaddrQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantedQ <= 1'b0;
      modQ     <= 1'b0;
      ppnQ     <= '0;
      failQ    <= '0;
    end else if (strobe.takeResult) begin
      grantedQ <= grantNow;
      modQ     <= entWr;
      ppnQ     <= entryQ[PPN_W-1:0];
      failQ    <= failNext;
    end
  end

  assign granted  = grantedQ;
  assign fillMod  = modQ;
  assign fillPpn  = ppnQ;
  assign failWord = failQ;
  assign install  = done & grantedQ & ~conQ;

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walk_pkg::*;
#(
  parameter int VA_W            = 18,
  parameter int OFS_W           = 9,
  parameter int PA_W            = 20,
  parameter int WORD_W          = 36,
  parameter int USER_MAP_OFS    = 'o0,
  parameter int EXEC_LOW_OFS    = 'o600,
  parameter int EXEC_MID_OFS    = 'o400,
  parameter int EXEC_HIGH_OFS   = 'o200,
  parameter int EXEC_MID_START  = 'o340,
  parameter int EXEC_HIGH_START = 'o400
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [VA_W-1:0]   vaddr,
  input  logic              isUser,
  input  logic              isWrite,
  input  logic              isMap,
  input  logic              isConsole,
  input  logic [PA_W-1:0]   execBase,
  input  logic [PA_W-1:0]   userBase,
  output logic              memReq,
  output logic [PA_W-1:0]   memAddr,
  input  logic              memAck,
  input  logic [WORD_W-1:0] memRdata,
  output logic              done,
  output logic              granted,
  output logic              install,
  output logic [PA_W-OFS_W-1:0] fillPpn,
  output logic              fillMod,
  output logic [WORD_W-1:0] failWord
);

  walkStrobe_t strobe;

  pt_walk_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .memAck (memAck),
    .strobe (strobe),
    .memReq (memReq),
    .done   (done)
  );

  pt_walk_dp #(
    .VA_W            (VA_W),
    .OFS_W           (OFS_W),
    .PA_W            (PA_W),
    .WORD_W          (WORD_W),
    .USER_MAP_OFS    (USER_MAP_OFS),
    .EXEC_LOW_OFS    (EXEC_LOW_OFS),
    .EXEC_MID_OFS    (EXEC_MID_OFS),
    .EXEC_HIGH_OFS   (EXEC_HIGH_OFS),
    .EXEC_MID_START  (EXEC_MID_START),
    .EXEC_HIGH_START (EXEC_HIGH_START)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .done      (done),
    .vaddr     (vaddr),
    .isUser    (isUser),
    .isWrite   (isWrite),
    .isMap     (isMap),
    .isConsole (isConsole),
    .execBase  (execBase),
    .userBase  (userBase),
    .memRdata  (memRdata),
    .memAddr   (memAddr),
    .granted   (granted),
    .install   (install),
    .fillPpn   (fillPpn),
    .fillMod   (fillMod),
    .failWord  (failWord)
  );

endmodule

// File: rtl/pt_walk_chk.sv
module pt_walk_chk #(
  parameter int PA_W = 20
) (
  input logic            clk,
  input logic            rstN,
  input logic            memReq,
  input logic            memAck,
  input logic [PA_W-1:0] memAddr,
  input logic            done,
  input logic            granted,
  input logic            install
);

  p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr));

  p_one_read_r11: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memAck |=> !memReq);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_no_req_at_done_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memReq);

  p_install_grant_r10: assert property (@(posedge clk) disable iff (!rstN)
    install |-> done && granted);

endmodule

bind pt_walker pt_walk_chk #(.PA_W(PA_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .memReq  (memReq),
  .memAck  (memAck),
  .memAddr (memAddr),
  .done    (done),
  .granted (granted),
  .install (install)
);

// File: tb/sim_pt_walker.sv
`timescale 1ns/1ps
module sim_pt_walker;

  localparam logic [19:0] U_OFS  = 20'o0;
  localparam logic [19:0] EL_OFS = 20'o600;
  localparam logic [19:0] EM_OFS = 20'o400;
  localparam logic [19:0] EH_OFS = 20'o200;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [17:0] vaddr = '0;
  logic        isUser = 1'b0, isWrite = 1'b0, isMap = 1'b0, isConsole = 1'b0;
  logic [19:0] execBase = '0, userBase = '0;
  logic        memReq;
  logic [19:0] memAddr;
  logic        memAck = 1'b0;
  logic [35:0] memRdata = '0;
  logic        done, granted, install, fillMod;
  logic [10:0] fillPpn;
  logic [35:0] failWord;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  pt_walker u0 (
    .clk(clk), .rstN(rstN), .start(start), .vaddr(vaddr),
    .isUser(isUser), .isWrite(isWrite), .isMap(isMap), .isConsole(isConsole),
    .execBase(execBase), .userBase(userBase),
    .memReq(memReq), .memAddr(memAddr), .memAck(memAck), .memRdata(memRdata),
    .done(done), .granted(granted), .install(install),
    .fillPpn(fillPpn), .fillMod(fillMod), .failWord(failWord)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] expAddr(input logic [8:0] pg, input bit usr,
                                          input logic [19:0] eb, input logic [19:0] ub);
    logic [8:0] rel;
    if (usr) begin
      rel = pg >> 1;
      return ub + U_OFS + {11'b0, rel};
    end else if (pg < 9'o340) begin
      rel = pg >> 1;
      return eb + EL_OFS + {11'b0, rel};
    end else if (pg < 9'o400) begin
      rel = (pg - 9'o340) >> 1;
      return ub + EM_OFS + {11'b0, rel};
    end else begin
      rel = (pg - 9'o400) >> 1;
      return eb + EH_OFS + {11'b0, rel};
    end
  endfunction

  function automatic string regionTag(input logic [8:0] pg, input bit usr);
    if (usr) return "R1";
    if (pg < 9'o340) return "R2";
    if (pg < 9'o400) return "R3";
    return "R4";
  endfunction

  function automatic logic [35:0] expFail(input logic [17:0] va, input bit usr, input bit wr,
                                          input bit mp, input logic [17:0] ent);
    logic [35:0] fw;
    fw = '0;
    fw[35] = 1'b1;
    fw[34] = usr;
    fw[33] = wr;
    fw[32] = ent[17];
    fw[31] = ent[15] & (ent[17] | mp);
    fw[30] = ent[16] & mp;
    fw[29] = ent[14] & mp;
    fw[17:0] = va;
    return fw;
  endfunction

  task automatic walk(input logic [17:0] va, input bit usr, input bit wr, input bit mp,
                      input bit con, input logic [19:0] eb, input logic [19:0] ub,
                      input logic [35:0] word, input int delay, input bit extraStart);
    logic [17:0] ent;
    bit expGrant;
    int n;
    ent = va[9] ? word[17:0] : word[35:18];
    expGrant = ent[17] & (~wr | ent[16]);
    @(negedge clk);
    vaddr = va; isUser = usr; isWrite = wr; isMap = mp; isConsole = con;
    execBase = eb; userBase = ub; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!memReq && n < 20) begin @(negedge clk); n++; end
    check({"R11 request raised"}, {35'b0, memReq}, 36'd1);
    check(regionTag(va[17:9], usr), {16'b0, memAddr}, {16'b0, expAddr(va[17:9], usr, eb, ub)});
    if (extraStart) begin
      // R11: a start while busy must not restart or retarget the walk
      vaddr = ~va; isUser = ~usr; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R11 address held after busy start", {16'b0, memAddr},
            {16'b0, expAddr(va[17:9], usr, eb, ub)});
    end
    for (int i = 0; i < delay; i++) @(negedge clk);
    check("R11 request held until ack", {35'b0, memReq}, 36'd1);
    memAck = 1'b1; memRdata = word;
    @(negedge clk);
    memAck = 1'b0; memRdata = ~word;
    check("R11 single read", {35'b0, memReq}, 36'd0);
    n = 0;
    while (!done && n < 20) begin @(negedge clk); n++; end
    check("R11 done raised", {35'b0, done}, 36'd1);
    check("R6 granted", {35'b0, granted}, {35'b0, expGrant});
    if (expGrant) begin
      check("R7 ppn", {25'b0, fillPpn}, {25'b0, ent[10:0]});
      check("R7 modified", {35'b0, fillMod}, {35'b0, ent[16]});
      check("R5 half select ppn", {25'b0, fillPpn}, {25'b0, ent[10:0]});
    end
    check(mp ? "R9 map fail word" : "R8 fail word", failWord, expFail(va, usr, wr, mp, ent));
    check("R10 install", {35'b0, install}, {35'b0, expGrant & ~con});
    @(negedge clk);
    check("R11 done one cycle", {35'b0, done}, 36'd0);
    check("R10 no install after done", {35'b0, install}, 36'd0);
  endtask

  function automatic logic [17:0] mkEnt(input bit a, input bit w, input bit s, input bit c,
                                        input logic [10:0] ppn);
    return {a, w, s, c, 3'b0, ppn};
  endfunction

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    check("R11 reset memReq", {35'b0, memReq}, 36'd0);
    check("R11 reset done", {35'b0, done}, 36'd0);
    check("R10 reset install", {35'b0, install}, 36'd0);
    rstN = 1'b1;
    @(negedge clk);

    // region boundaries, exec space
    walk({9'o337, 9'o5}, 0, 0, 0, 0, 20'o10000, 20'o20000,
         {mkEnt(1,0,0,0,11'o1234), mkEnt(0,0,0,0,0)}, 0, 0);           // R2 odd page right half
    walk({9'o340, 9'o0}, 0, 0, 0, 0, 20'o10000, 20'o20000,
         {mkEnt(1,1,0,0,11'o17), mkEnt(0,0,0,0,11'o7)}, 1, 0);         // R3 even page left half
    walk({9'o377, 9'o1}, 0, 1, 0, 0, 20'o10000, 20'o20000,
         {mkEnt(0,0,0,0,0), mkEnt(1,1,1,0,11'o777)}, 2, 0);            // R3 top of band
    walk({9'o400, 9'o0}, 0, 1, 0, 0, 20'o10000, 20'o20000,
         {mkEnt(1,0,1,1,11'o55), mkEnt(1,1,1,1,11'o66)}, 0, 0);        // R4 write denied R6
    walk({9'o777, 9'o777}, 0, 0, 0, 0, 20'o10000, 20'o20000,
         {mkEnt(0,0,0,0,0), mkEnt(1,0,1,0,11'o3)}, 0, 0);              // R4 last page
    // user space, map query, console
    walk({9'o350, 9'o0}, 1, 0, 1, 0, 20'o10000, 20'o20000,
         {mkEnt(0,1,1,1,11'o1), mkEnt(0,0,0,0,0)}, 1, 0);              // R1 R9 inaccessible map
    walk({9'o000, 9'o0}, 1, 1, 1, 1, 20'o10000, 20'o20000,
         {mkEnt(1,1,0,1,11'o2), mkEnt(0,0,0,0,0)}, 0, 0);              // R10 console grant
    walk({9'o101, 9'o7}, 0, 0, 0, 0, 20'o10000, 20'o20000,
         {mkEnt(0,0,1,0,0), mkEnt(1,0,1,0,11'o44)}, 3, 1);             // R11 busy start
    walk({9'o2, 9'o0}, 0, 0, 0, 0, 20'hFFFF0, 20'h00000,
         {mkEnt(1,0,0,0,11'o5), mkEnt(0,0,0,0,0)}, 0, 0);              // R2 address wrap

    for (int k = 0; k < 400; k++) begin
      logic [17:0] va;
      logic [35:0] w;
      va = 18'($urandom);
      w  = {4'($urandom), 32'($urandom)};
      walk(va, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           20'($urandom), 20'($urandom), w, int'($urandom_range(0, 3)),
           ($urandom_range(0, 7) == 0));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule